// File: doc/BRIEF.md
# Serial Byte Transmitter with Flow Gating

This block turns bytes into asynchronous serial frames on one output line. Bytes enter through a push port into a 16-entry queue. A state machine takes them from the queue one at a time and shifts them out. Its pace comes from a baud tick enable that an external divider produces. Each bit lasts either 16 ticks or 8 ticks, depending on a speed select. The select is taken once, when a character starts.

Two enable inputs must both be high before a new character may leave the queue. A clear-to-send input can also hold new characters back, but only while flow gating is switched on. The gate is tested only at a character boundary. A character that has started always runs to the end of its stop bit, whatever happens to the enables or to clear-to-send. A single status flag has two meanings, chosen by a mode input: either the queue is at or below a threshold, or the line has fully drained.

The state machine has four states. IDLE holds the line high. It moves to START, which pops a byte, when the queue is not empty and start is allowed. START moves to DATA after one bit time. DATA moves to STOP after the eighth data bit. STOP returns to IDLE after one bit time.

Top module: `sertx_core`

## Requirements
- R1: The line idles high. A frame is one low start bit, then eight data bits with bit 0 first, then one high stop bit. Each bit lasts a fixed number of baud ticks.
- R2: With `fast_mode` = 0 a bit lasts 16 ticks, and with `fast_mode` = 1 it lasts 8 ticks. The value is captured when the character starts, so changing it mid-character does not alter that character.
- R3: A new character starts only while `en_all` and `en_tx` are both 1 and the queue is not empty. With either enable at 0 the line stays high.
- R4: If an enable drops while a character is in flight, that character completes through its stop bit. No further character starts until both enables are high again.
- R5: With `cts_gate_on` = 1, a character starts only while `cts_in` = 1. A drop of `cts_in` during a character does not cut it short. With `cts_gate_on` = 0, `cts_in` is ignored.
- R6: With `eot_mode` = 1, `status_flag` is 1 exactly when the queue is empty and no frame is on the line, stop bit included.
- R7: With `eot_mode` = 0, `status_flag` is 1 exactly when the queue occupancy is at or below `fifo_thresh`.
- R8: The queue holds 16 bytes, and `fifo_full` is high when it holds 16. A write while full is dropped. `overflow_pulse` goes high for one cycle, in the cycle after that write.
- R9: Bytes leave in the order they were written.
- R10: After reset the line is high, the queue is empty, and `overflow_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_all | input | 1 | Global enable |
| en_tx | input | 1 | Transmit enable |
| cts_gate_on | input | 1 | Gate character starts on `cts_in` |
| cts_in | input | 1 | Clear-to-send, 1 = peer ready |
| fast_mode | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| eot_mode | input | 1 | Status meaning: 1 drained, 0 threshold |
| fifo_thresh | input | 5 | Occupancy threshold for threshold mode |
| baud_tick | input | 1 | One-cycle baud tick enable |
| wr_valid | input | 1 | Push a byte this cycle |
| wr_data | input | 8 | Byte to push |
| tx_out | output | 1 | Serial line |
| status_flag | output | 1 | Transmit status per `eot_mode` |
| fifo_full | output | 1 | Queue holds 16 bytes |
| overflow_pulse | output | 1 | A write to a full queue was dropped |

## Verification
A bad state, bit counter or tick counter shows up on `tx_out`. It takes the form of a bit of the wrong length, a misplaced or missing stop bit, or a shifted byte, and it appears within one frame. A wrong queue pointer or count shows up as a reordered or lost byte in the decoded stream. It can also show as a wrong `status_flag` or `fifo_full` in the cycle after the push or pop that caused it. A wrong start decision shows as a falling edge on `tx_out` in a window where the enables or clear-to-send forbid one. That edge appears within one clock of the illegal start.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_e;

    localparam int unsigned SLOW_TICKS = 16;
    localparam int unsigned FAST_TICKS = 8;
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty,
    output logic             ovf
);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_q, wr_q;
    logic [CW-1:0]    cnt_q;
    logic             ovf_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == FULL_CNT);
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_q];
    assign count   = cnt_q;
    assign ovf     = ovf_q;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= push && full;
            if (do_push) begin
                wr_q <= (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
            end
            if (do_pop) begin
                rd_q <= (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_ok,
    input  logic              has_data,
    input  logic [DATA_W-1:0] data_in,
    input  logic              fast_mode,
    input  logic              baud_tick,
    output logic              pop,
    output logic              busy,
    output logic              tx_out
);
    localparam int unsigned TICK_W = $clog2(SLOW_TICKS);
    localparam int unsigned IDX_W  = $clog2(DATA_W);
    localparam logic [TICK_W-1:0] SLOW_LAST = TICK_W'(SLOW_TICKS - 1);
    localparam logic [TICK_W-1:0] FAST_LAST = TICK_W'(FAST_TICKS - 1);
    localparam logic [IDX_W-1:0]  LAST_BIT  = IDX_W'(DATA_W - 1);

    tx_state_e         state_q, state_d;
    logic [TICK_W-1:0] tick_q, last_q;
    logic [IDX_W-1:0]  bit_q;
    logic [DATA_W-1:0] sh_q;
    logic              bit_done;

    assign bit_done = baud_tick && (tick_q == last_q);

    // next state and pop decision
    always_comb begin
        state_d = state_q;
        pop     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (has_data && go_ok) begin
                    state_d = ST_START;
                    pop     = 1'b1;
                end
            end
            ST_START: if (bit_done) state_d = ST_DATA;
            ST_DATA:  if (bit_done && bit_q == LAST_BIT) state_d = ST_STOP;
            ST_STOP:  if (bit_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tick_q  <= '0;
            last_q  <= SLOW_LAST;
            bit_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                if (pop) begin
                    sh_q   <= data_in;
                    tick_q <= '0;
                    bit_q  <= '0;
                    last_q <= fast_mode ? FAST_LAST : SLOW_LAST;
                end
            end else if (baud_tick) begin
                tick_q <= bit_done ? '0 : tick_q + 1'b1;
                if (bit_done && state_q == ST_DATA) begin
                    sh_q  <= sh_q >> 1;
                    bit_q <= bit_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:  tx_out = 1'b1;
            ST_START: tx_out = 1'b0;
            ST_DATA:  tx_out = sh_q[0];
            ST_STOP:  tx_out = 1'b1;
            default:  tx_out = 1'b1;
        endcase
        busy = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/sertx_core.sv
module sertx_core #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned FIFO_DEPTH = 16,
    localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_all,
    input  logic              en_tx,
    input  logic              cts_gate_on,
    input  logic              cts_in,
    input  logic              fast_mode,
    input  logic              eot_mode,
    input  logic [CNT_W-1:0]  fifo_thresh,
    input  logic              baud_tick,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_out,
    output logic              status_flag,
    output logic              fifo_full,
    output logic              overflow_pulse
);
    logic [DATA_W-1:0] head;
    logic [CNT_W-1:0]  fifo_count;
    logic              fifo_empty, pop, busy, go_ok;

    assign go_ok = en_all && en_tx && (!cts_gate_on || cts_in);

    sertx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_valid),
        .din   (wr_data),
        .pop   (pop),
        .dout  (head),
        .count (fifo_count),
        .full  (fifo_full),
        .empty (fifo_empty),
        .ovf   (overflow_pulse)
    );

    sertx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_ok     (go_ok),
        .has_data  (!fifo_empty),
        .data_in   (head),
        .fast_mode (fast_mode),
        .baud_tick (baud_tick),
        .pop       (pop),
        .busy      (busy),
        .tx_out    (tx_out)
    );

    assign status_flag = eot_mode ? (fifo_empty && !busy)
                                  : (fifo_count <= fifo_thresh);
endmodule

// File: rtl/sertx_checks.sv
module sertx_checks #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_all,
    input logic          en_tx,
    input logic          cts_gate_on,
    input logic          cts_in,
    input logic          wr_valid,
    input logic          fifo_full,
    input logic          overflow_pulse,
    input logic          eot_mode,
    input logic          status_flag,
    input logic          tx_out,
    input logic          busy,
    input logic [CW-1:0] fifo_count
);
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_out);

    a_r3_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(en_all && en_tx)) |=> !busy);

    a_r5_cts_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cts_gate_on && !cts_in) |=> !busy);

    a_r6_busy_not_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_mode && busy) |-> !status_flag);

    a_r8_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && fifo_full) |=> overflow_pulse);

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));
endmodule

bind sertx_core sertx_checks #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_checks (
    .clk            (clk),
    .rst_n          (rst_n),
    .en_all         (en_all),
    .en_tx          (en_tx),
    .cts_gate_on    (cts_gate_on),
    .cts_in         (cts_in),
    .wr_valid       (wr_valid),
    .fifo_full      (fifo_full),
    .overflow_pulse (overflow_pulse),
    .eot_mode       (eot_mode),
    .status_flag    (status_flag),
    .tx_out         (tx_out),
    .busy           (busy),
    .fifo_count     (fifo_count)
);

// File: tb/sertx_core_bench.sv
`timescale 1ns/1ps
module sertx_core_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_all = 1'b0, en_tx = 1'b0, cts_gate_on = 1'b0, cts_in = 1'b0;
    logic fast_mode = 1'b0, eot_mode = 1'b1, baud_tick = 1'b0, wr_valid = 1'b0;
    logic [4:0] fifo_thresh = 5'd5;
    logic [7:0] wr_data = 8'h00;
    logic tx_out, status_flag, fifo_full, overflow_pulse;

    int nchk = 0;
    int nfail = 0;
    int tick_div = 1;
    int phase = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sertx_core u_sertx_core (
        .clk(clk), .rst_n(rst_n), .en_all(en_all), .en_tx(en_tx),
        .cts_gate_on(cts_gate_on), .cts_in(cts_in), .fast_mode(fast_mode),
        .eot_mode(eot_mode), .fifo_thresh(fifo_thresh), .baud_tick(baud_tick),
        .wr_valid(wr_valid), .wr_data(wr_data), .tx_out(tx_out),
        .status_flag(status_flag), .fifo_full(fifo_full),
        .overflow_pulse(overflow_pulse)
    );

    // baud tick source: one tick every tick_div cycles
    initial begin
        forever begin
            @(negedge clk);
            phase = (phase + 1) % tick_div;
            baud_tick = (phase == 0);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // decode one frame; cpb = clock cycles per bit
    task automatic recv(input int cpb, output logic [7:0] b);
        int w = 0;
        b = 8'h00;
        @(negedge clk);
        while (tx_out === 1'b1 && w < 20000) begin
            @(negedge clk);
            w++;
        end
        if (w >= 20000) begin
            chk(1'b0, "R1 no start bit seen", 0, 1);
            return;
        end
        repeat (cpb / 2) @(negedge clk);
        chk(tx_out == 1'b0, "R1 start bit low", int'(tx_out), 0);
        for (int i = 0; i < 8; i++) begin
            repeat (cpb) @(negedge clk);
            b[i] = tx_out;
        end
        repeat (cpb) @(negedge clk);
        chk(tx_out == 1'b1, "R1 stop bit high", int'(tx_out), 1);
    endtask

    task automatic quiet(input int cycles, input string tag);
        int lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tx_out !== 1'b1) lows++;
        end
        chk(lows == 0, tag, lows, 0);
    endtask

    initial begin
        #200000;
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", nchk, 0);
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] got;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(tx_out == 1'b1, "R10 line high", int'(tx_out), 1);
        chk(fifo_full == 1'b0, "R10 not full", int'(fifo_full), 0);
        chk(overflow_pulse == 1'b0, "R10 no overflow", int'(overflow_pulse), 0);
        chk(status_flag == 1'b1, "R10/R6 drained after reset", int'(status_flag), 1);

        // R7 threshold sweep over every occupancy, R8 fill and drop
        eot_mode = 1'b0;
        for (int k = 0; k <= 16; k++) begin
            @(negedge clk);
            chk(status_flag == (k <= 5), "R7 threshold flag", int'(status_flag), int'(k <= 5));
            chk(fifo_full == (k == 16), "R8 full flag", int'(fifo_full), int'(k == 16));
            if (k < 16) push(8'hA0 + 8'(k));
        end
        push(8'hEE);
        chk(overflow_pulse == 1'b1, "R8 overflow pulse", int'(overflow_pulse), 1);
        @(negedge clk);
        chk(overflow_pulse == 1'b0, "R8 overflow one cycle", int'(overflow_pulse), 0);
        eot_mode = 1'b1;
        @(negedge clk);
        chk(status_flag == 1'b0, "R6 queue not empty", int'(status_flag), 0);

        // R9 order, R2 fast bits, R8 dropped byte absent
        fast_mode = 1'b1;
        en_all = 1'b1;
        en_tx = 1'b1;
        for (int k = 0; k < 16; k++) begin
            recv(8, got);
            chk(got == 8'hA0 + 8'(k), "R9 order after fill", int'(got), 'hA0 + k);
        end
        chk(status_flag == 1'b0, "R6 stop bit still on line", int'(status_flag), 0);
        repeat (8) @(negedge clk);
        chk(status_flag == 1'b1, "R6 drained", int'(status_flag), 1);

        // R1/R2 full byte sweep, fast mode, writer runs alongside
        fork
            begin
                for (int v = 0; v < 256; v++) begin
                    while (fifo_full) @(negedge clk);
                    push(8'(v));
                end
            end
            begin
                for (int v = 0; v < 256; v++) begin
                    recv(8, got);
                    chk(got == 8'(v), "R1 byte sweep fast", int'(got), v);
                end
            end
        join

        // R2 slow mode at half tick rate, speed change mid-frame ignored
        fast_mode = 1'b0;
        tick_div = 2;
        for (int v = 0; v < 8; v++) begin
            fork
                push(8'h11 * 8'(v) ^ 8'h5C);
                begin
                    recv(32, got);
                    chk(got == (8'h11 * 8'(v) ^ 8'h5C), "R2 slow byte", int'(got),
                        int'(8'h11 * 8'(v) ^ 8'h5C));
                end
                begin
                    repeat (100) @(negedge clk);
                    fast_mode = 1'b1;
                end
            join
            fast_mode = 1'b0;
        end
        tick_div = 1;
        repeat (40) @(negedge clk);

        // R4 enable dropped mid-character
        en_tx = 1'b0;
        push(8'h5A);
        push(8'hC3);
        en_tx = 1'b1;
        fork
            recv(16, got);
            begin
                repeat (40) @(negedge clk);
                en_tx = 1'b0;
            end
        join
        chk(got == 8'h5A, "R4 character completed", int'(got), 'h5A);
        quiet(300, "R4 no start after disable");
        chk(status_flag == 1'b0, "R6 byte waiting", int'(status_flag), 0);
        en_tx = 1'b1;
        recv(16, got);
        chk(got == 8'hC3, "R4 resumes", int'(got), 'hC3);

        // R3 every disabled enable combination
        en_all = 1'b0;
        en_tx = 1'b0;
        push(8'h33);
        for (int c = 0; c < 3; c++) begin
            en_all = c[1];
            en_tx  = c[0];
            quiet(200, "R3 enable combination holds line");
        end
        en_all = 1'b1;
        en_tx = 1'b1;
        recv(16, got);
        chk(got == 8'h33, "R3 both enables start", int'(got), 'h33);

        // R5 clear-to-send gating
        cts_gate_on = 1'b1;
        cts_in = 1'b0;
        push(8'h96);
        quiet(300, "R5 gated by cts");
        cts_in = 1'b1;
        fork
            recv(16, got);
            begin
                repeat (50) @(negedge clk);
                cts_in = 1'b0;
            end
        join
        chk(got == 8'h96, "R5 cts drop mid-frame", int'(got), 'h96);
        cts_gate_on = 1'b0;
        push(8'h69);
        recv(16, got);
        chk(got == 8'h69, "R5 cts ignored when gate off", int'(got), 'h69);

        repeat (20) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule